// File: doc/BRIEF.md
# Command packet framer

The framer sits between a word-wide command port and a rasteriser's drawing engine. Command words are 32 bits wide and go into an input FIFO. The framer takes them out one at a time and uses the opcode in bits [31:24] of the first word to find where each packet ends. It gathers every packet into a local buffer and sends nothing until the last word is in. It then sends the packet downstream, one word per accepted beat of a valid/ready handshake. A flag marks the final word.

Three opcode groups are treated differently:
- **Polylines** have no fixed length. They close on a terminator word, or when the buffer is full.
- **Image-transfer commands** are three words long. They are not sent to the drawing engine. Instead they start a job on a separate transfer engine, and the framer stalls until that engine reports completion.
- **Environment commands** are stored in eight shadow registers. Selected fields of two of these registers appear on a 13-bit status output.

A synchronous command-reset input throws away any partly gathered packet and the FIFO contents, and ends an active transfer. It leaves the shadow registers unchanged.

Top module: `gpf_framer`

## Requirements
- R1: A packet is one header word plus a number of extra words set by the opcode. Examples of total packet length:
  - 0x02: 3 words
  - 0x20–0x23: 4 words
  - 0x3C–0x3F: 12 words
  - 0x80: 4 words
  - 0x00 and 0xE8: 1 word

  Only opcodes 0x02, 0x20–0x7F and 0x80 have extra words.
- R2: A flat polyline (opcodes 0x48–0x4F) closes on the first word at index 3 or higher that matches the terminator pattern. A word matches when (word & 0xF000F000) == 0x50005000. The terminator is the packet's last word. Words at indices 1–2 that match the pattern do not close the packet.
- R3: A shaded polyline (opcodes 0x58–0x5F) is tested for the terminator only at even indices of 4 or higher. A matching word at an odd index, or at an index below 4, does not close the packet.
- R4: A polyline with no terminator is closed when it reaches 12 words.
- R5: Opcodes 0xA0–0xDF take exactly 3 words: command, position and size. They produce no draw packet. They give a one-cycle `xfer_start` pulse with `xfer_pos` = word 1 and `xfer_size` = word 2. `xfer_read` is 1 when opcode[7:5] = 3'b110 and 0 otherwise.
- R6: From `xfer_start` until `xfer_done` is sampled high, no input word is consumed and no packet is sent.
- R7: Opcodes 0xE0–0xE7 store the whole word in shadow register opcode[2:0]. They produce no draw packet. `shd_data` shows shadow register `shd_sel`.
- R8: After reset:
  - shadow register i holds (0xE0 + i) << 24
  - `status_word` is 0
  - `pkt_valid` and `xfer_active` are low
  - `in_ready` is high
- R9: `status_word[10:0]` equals shadow register 1 bits [10:0], and `status_word[12:11]` equals shadow register 6 bits [1:0].
- R10: An incomplete packet is never sent. Once complete, its words go out in order, with `pkt_last` high on the final word only. `pkt_valid`, `pkt_data` and `pkt_last` hold steady while `pkt_ready` is low.
- R11: `cmd_reset` throws away the partly gathered packet and the FIFO contents, and ends an active transfer. It does not change the shadow registers.
- R12: The FIFO holds 16 words. `in_ready` is low when it is full, and no accepted word is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_reset | input | 1 | Synchronous flush of packet state, FIFO and transfer |
| in_valid | input | 1 | Command word offered |
| in_data | input | 32 | Command word |
| in_ready | output | 1 | FIFO can accept a word |
| pkt_valid | output | 1 | Draw packet word valid |
| pkt_ready | input | 1 | Drawing engine accepts the word |
| pkt_data | output | 32 | Draw packet word |
| pkt_last | output | 1 | Final word of the packet |
| xfer_start | output | 1 | One-cycle transfer start pulse |
| xfer_read | output | 1 | Transfer direction is read |
| xfer_pos | output | 32 | Transfer position word |
| xfer_size | output | 32 | Transfer size word |
| xfer_active | output | 1 | Transfer in progress, framing stalled |
| xfer_done | input | 1 | Transfer engine finished |
| shd_sel | input | 3 | Shadow register select |
| shd_data | output | 32 | Selected shadow register |
| status_word | output | 13 | Status fields mirrored from shadow registers |

## Verification
The hardest cases to reach from the ports are a FIFO that fills while a finished packet is blocked downstream, and a `cmd_reset` that arrives while the FIFO still holds a word queued behind an active transfer.

The bench reaches the first by holding `pkt_ready` low after a 12-word packet and then pushing 16 one-word packets. It reaches the second by holding `xfer_done` low so the transfer stays open, then pulsing `cmd_reset`. A queued word that leaks through would then appear as an unexpected packet.

The polyline stimulus places decoy terminator patterns at indices where they must be ignored.

// File: rtl/gpf_pkg.sv
package gpf_pkg;

  localparam int WORD_W   = 32;
  localparam int STATUS_W = 13;

  typedef enum logic [1:0] {ST_COLLECT, ST_EMIT, ST_XFER} asm_state_t;

  // Extra words following the header, decoded from opcode fields.
  function automatic logic [3:0] extra_words(input logic [7:0] op);
    logic [3:0] n;
    n = 4'd0;
    if (op == 8'h02) n = 4'd2;
    else if (op == 8'h80) n = 4'd3;
    else if (op[7:5] == 3'b001) begin
      case (op[4:2])
        3'd0: n = 4'd3;
        3'd1: n = 4'd6;
        3'd2: n = 4'd4;
        3'd3: n = 4'd8;
        3'd4: n = 4'd5;
        3'd5: n = 4'd8;
        3'd6: n = 4'd7;
        default: n = 4'd11;
      endcase
    end else if (op[7:6] == 2'b01) begin
      case (op[5:2])
        4'd0, 4'd1, 4'd8:             n = 4'd2;
        4'd2, 4'd3, 4'd4, 4'd5, 4'd9: n = 4'd3;
        4'd6, 4'd7:                   n = 4'd4;
        4'd10, 4'd12, 4'd14:          n = 4'd1;
        4'd13, 4'd15:                 n = 4'd2;
        default:                      n = 4'd0;
      endcase
    end
    return n;
  endfunction

  function automatic logic is_flat_poly(input logic [7:0] op);
    return op[7:3] == 5'b01001;
  endfunction

  function automatic logic is_shaded_poly(input logic [7:0] op);
    return op[7:3] == 5'b01011;
  endfunction

  function automatic logic is_xfer_op(input logic [7:0] op);
    return (op[7:5] == 3'b101) || (op[7:5] == 3'b110);
  endfunction

  function automatic logic is_xfer_read(input logic [7:0] op);
    return op[7:5] == 3'b110;
  endfunction

  function automatic logic is_env_op(input logic [7:0] op);
    return op[7:3] == 5'b11100;
  endfunction

  function automatic logic is_terminator(input logic [WORD_W-1:0] w);
    return (w & 32'hF000_F000) == 32'h5000_5000;
  endfunction

  function automatic logic [WORD_W-1:0] shadow_reset(input logic [2:0] i);
    return {5'b11100, i, 24'h0};
  endfunction

  // True when the word at index idx is the last one of its packet.
  function automatic logic closes_packet(input logic [7:0] op, input logic [7:0] idx,
                                         input logic [WORD_W-1:0] w, input logic [7:0] last_idx);
    logic hit;
    if (is_xfer_op(op))          hit = (idx == 8'd2);
    else if (is_flat_poly(op))   hit = (idx >= 8'd3) && is_terminator(w);
    else if (is_shaded_poly(op)) hit = (idx >= 8'd4) && !idx[0] && is_terminator(w);
    else                         hit = (idx == {4'd0, extra_words(op)});
    return hit || (idx == last_idx);
  endfunction

endpackage

// File: rtl/gpf_fifo.sv
module gpf_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [W-1:0]               wdata,
  output logic                       full,
  input  logic                       pop,
  output logic [W-1:0]               rdata,
  output logic                       empty,
  output logic [$clog2(DEPTH):0]     count
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0]   FULL_CNT = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;
  logic          do_push, do_pop;

  assign full    = (cnt_q == FULL_CNT);
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem_q[rp_q];
  assign count   = cnt_q;

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem_q[wp_q] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == LAST_PTR) ? '0 : wp_q + AW'(1);
      if (do_pop)  rp_q <= (rp_q == LAST_PTR) ? '0 : rp_q + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + (AW+1)'(1);
        2'b01:   cnt_q <= cnt_q - (AW+1)'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/gpf_shadow.sv
module gpf_shadow import gpf_pkg::*; #(
  parameter int NREGS = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [$clog2(NREGS)-1:0]  idx,
  input  logic [WORD_W-1:0]         wdata,
  input  logic [$clog2(NREGS)-1:0]  sel,
  output logic [WORD_W-1:0]         rdata,
  output logic [STATUS_W-1:0]       status
);
  localparam int IXW = $clog2(NREGS);

  logic [WORD_W-1:0] regs_q [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          regs_q[g] <= shadow_reset(3'(g));
      else if (we && (idx == IXW'(g)))     regs_q[g] <= wdata;
    end
  end

  assign rdata  = regs_q[sel];
  assign status = {regs_q[6][1:0], regs_q[1][10:0]};
endmodule

// File: rtl/gpf_assembler.sv
module gpf_assembler import gpf_pkg::*; #(
  parameter int MAX_WORDS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              fifo_empty,
  input  logic [WORD_W-1:0] fifo_rdata,
  output logic              fifo_pop,
  output logic              pkt_valid,
  input  logic              pkt_ready,
  output logic [WORD_W-1:0] pkt_data,
  output logic              pkt_last,
  output logic              xfer_start,
  output logic              xfer_read,
  output logic [WORD_W-1:0] xfer_pos,
  output logic [WORD_W-1:0] xfer_size,
  output logic              xfer_active,
  input  logic              xfer_done,
  output logic              shd_we,
  output logic [2:0]        shd_idx,
  output logic [WORD_W-1:0] shd_wdata
);
  localparam int IW = $clog2(MAX_WORDS + 1);
  localparam logic [7:0] LAST_IDX = 8'(MAX_WORDS - 1);

  asm_state_t        state_q;
  logic [WORD_W-1:0] buf_q [MAX_WORDS];
  logic [IW-1:0]     cnt_q, rd_q, len_q;
  logic [7:0]        op_q;
  logic [WORD_W-1:0] pos_q, size_q;
  logic              start_q, read_q;

  logic       take, hdr, env_hit, close_now;
  logic [7:0] op_now;

  always_comb begin
    take      = (state_q == ST_COLLECT) && !fifo_empty;
    hdr       = (cnt_q == '0);
    op_now    = hdr ? fifo_rdata[31:24] : op_q;
    env_hit   = take && hdr && is_env_op(op_now);
    close_now = take && !env_hit && closes_packet(op_now, 8'(cnt_q), fifo_rdata, LAST_IDX);
  end

  assign fifo_pop    = take;
  assign shd_we      = env_hit;
  assign shd_idx     = op_now[2:0];
  assign shd_wdata   = fifo_rdata;
  assign pkt_valid   = (state_q == ST_EMIT);
  assign pkt_data    = buf_q[rd_q];
  assign pkt_last    = (rd_q == len_q - IW'(1));
  assign xfer_active = (state_q == ST_XFER);
  assign xfer_start  = start_q;
  assign xfer_read   = read_q;
  assign xfer_pos    = pos_q;
  assign xfer_size   = size_q;

  always_ff @(posedge clk) begin
    if (take && !env_hit && !flush) buf_q[cnt_q] <= fifo_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_COLLECT;
      cnt_q   <= '0;
      rd_q    <= '0;
      len_q   <= '0;
      op_q    <= '0;
      start_q <= 1'b0;
      read_q  <= 1'b0;
      pos_q   <= '0;
      size_q  <= '0;
    end else if (flush) begin
      state_q <= ST_COLLECT;
      cnt_q   <= '0;
      rd_q    <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      case (state_q)
        ST_COLLECT: begin
          if (take && !env_hit) begin
            if (hdr) op_q <= fifo_rdata[31:24];
            if (close_now) begin
              cnt_q <= '0;
              if (is_xfer_op(op_now)) begin
                state_q <= ST_XFER;
                start_q <= 1'b1;
                read_q  <= is_xfer_read(op_now);
                pos_q   <= buf_q[1];
                size_q  <= fifo_rdata;
              end else begin
                state_q <= ST_EMIT;
                len_q   <= cnt_q + IW'(1);
                rd_q    <= '0;
              end
            end else begin
              cnt_q <= cnt_q + IW'(1);
            end
          end
        end
        ST_EMIT: begin
          if (pkt_ready) begin
            if (pkt_last) state_q <= ST_COLLECT;
            else          rd_q    <= rd_q + IW'(1);
          end
        end
        ST_XFER: begin
          if (xfer_done) state_q <= ST_COLLECT;
        end
        default: state_q <= ST_COLLECT;
      endcase
    end
  end
endmodule

// File: rtl/gpf_framer.sv
module gpf_framer import gpf_pkg::*; #(
  parameter int FIFO_DEPTH = 16,
  parameter int MAX_WORDS  = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_reset,
  input  logic                in_valid,
  input  logic [31:0]         in_data,
  output logic                in_ready,
  output logic                pkt_valid,
  input  logic                pkt_ready,
  output logic [31:0]         pkt_data,
  output logic                pkt_last,
  output logic                xfer_start,
  output logic                xfer_read,
  output logic [31:0]         xfer_pos,
  output logic [31:0]         xfer_size,
  output logic                xfer_active,
  input  logic                xfer_done,
  input  logic [2:0]          shd_sel,
  output logic [31:0]         shd_data,
  output logic [12:0]         status_word
);
  localparam int CW = $clog2(FIFO_DEPTH) + 1;

  logic              fifo_full, fifo_empty, fifo_pop;
  logic [WORD_W-1:0] fifo_rdata;
  logic [CW-1:0]     fifo_count;
  logic              shd_we;
  logic [2:0]        shd_idx;
  logic [WORD_W-1:0] shd_wdata;

  assign in_ready = !fifo_full;

  gpf_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) fifo_i (
    .clk(clk), .rst_n(rst_n), .flush(cmd_reset),
    .push(in_valid), .wdata(in_data), .full(fifo_full),
    .pop(fifo_pop), .rdata(fifo_rdata), .empty(fifo_empty), .count(fifo_count)
  );

  gpf_assembler #(.MAX_WORDS(MAX_WORDS)) asm_i (
    .clk(clk), .rst_n(rst_n), .flush(cmd_reset),
    .fifo_empty(fifo_empty), .fifo_rdata(fifo_rdata), .fifo_pop(fifo_pop),
    .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_data(pkt_data), .pkt_last(pkt_last),
    .xfer_start(xfer_start), .xfer_read(xfer_read), .xfer_pos(xfer_pos),
    .xfer_size(xfer_size), .xfer_active(xfer_active), .xfer_done(xfer_done),
    .shd_we(shd_we), .shd_idx(shd_idx), .shd_wdata(shd_wdata)
  );

  gpf_shadow #(.NREGS(8)) shadow_i (
    .clk(clk), .rst_n(rst_n), .we(shd_we), .idx(shd_idx), .wdata(shd_wdata),
    .sel(shd_sel), .rdata(shd_data), .status(status_word)
  );
endmodule

// File: rtl/gpf_framer_chk.sv
module gpf_framer_chk #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cmd_reset,
  input logic                       in_ready,
  input logic                       pkt_valid,
  input logic                       pkt_ready,
  input logic [31:0]                pkt_data,
  input logic                       pkt_last,
  input logic                       xfer_start,
  input logic                       xfer_active,
  input logic                       fifo_pop,
  input logic [$clog2(DEPTH):0]     fifo_count,
  input logic                       shd_we,
  input logic [2:0]                 shd_idx,
  input logic [31:0]                shd_wdata,
  input logic [12:0]                status_word
);
  localparam int CW = $clog2(DEPTH) + 1;

  p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CW'(DEPTH));

  p_full_stall_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count == CW'(DEPTH)) |-> !in_ready);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_ready && !cmd_reset) |=> (pkt_valid && $stable(pkt_data) && $stable(pkt_last)));

  p_xfer_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_active |-> (!pkt_valid && !fifo_pop));

  p_start_in_xfer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> xfer_active);

  p_start_on_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_active) |-> xfer_start);

  p_env_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    shd_we |-> !pkt_valid);

  p_status_mirror_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (shd_we && shd_idx == 3'd1 && !cmd_reset) |=> (status_word[10:0] == $past(shd_wdata[10:0])));

  p_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |=> (!pkt_valid && !xfer_active && fifo_count == '0));
endmodule

bind gpf_framer gpf_framer_chk #(.DEPTH(FIFO_DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_reset(cmd_reset), .in_ready(in_ready),
  .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_data(pkt_data), .pkt_last(pkt_last),
  .xfer_start(xfer_start), .xfer_active(xfer_active), .fifo_pop(fifo_pop),
  .fifo_count(fifo_count), .shd_we(shd_we), .shd_idx(shd_idx), .shd_wdata(shd_wdata),
  .status_word(status_word)
);

// File: tb/gpf_framer_tb.sv
module gpf_framer_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0, cmd_reset = 1'b0, in_valid = 1'b0, in_ready;
  logic [31:0] in_data = '0;
  logic        pkt_valid, pkt_ready = 1'b0, pkt_last;
  logic [31:0] pkt_data;
  logic        xfer_start, xfer_read, xfer_active, xfer_done = 1'b0;
  logic [31:0] xfer_pos, xfer_size;
  logic [2:0]  shd_sel = '0;
  logic [31:0] shd_data;
  logic [12:0] status_word;

  gpf_framer dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_reset(cmd_reset), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_data(pkt_data),
    .pkt_last(pkt_last), .xfer_start(xfer_start), .xfer_read(xfer_read), .xfer_pos(xfer_pos),
    .xfer_size(xfer_size), .xfer_active(xfer_active), .xfer_done(xfer_done),
    .shd_sel(shd_sel), .shd_data(shd_data), .status_word(status_word)
  );

  int          n_checks = 0, n_fail = 0, rx_words = 0, cyc = 0;
  logic [31:0] exp_w [$];
  logic        exp_l [$];
  string       exp_t [$];
  logic [64:0] exp_x [$];
  logic        rdy_en = 1'b1, done_en = 1'b1;
  logic [31:0] sh_m [8];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // Extra-word counts restated as opcode ranges (R1).
  function automatic int bench_extra(input logic [7:0] op);
    if (op == 8'h02) return 2;
    if (op == 8'h80) return 3;
    if (op inside {[8'h20:8'h23]}) return 3;
    if (op inside {[8'h24:8'h27]}) return 6;
    if (op inside {[8'h28:8'h2B]}) return 4;
    if (op inside {[8'h2C:8'h2F], [8'h34:8'h37]}) return 8;
    if (op inside {[8'h30:8'h33]}) return 5;
    if (op inside {[8'h38:8'h3B]}) return 7;
    if (op inside {[8'h3C:8'h3F]}) return 11;
    if (op inside {[8'h40:8'h47], [8'h60:8'h63], [8'h74:8'h77], [8'h7C:8'h7F]}) return 2;
    if (op inside {[8'h48:8'h57], [8'h64:8'h67]}) return 3;
    if (op inside {[8'h58:8'h5F]}) return 4;
    if (op inside {[8'h68:8'h6B], [8'h70:8'h73], [8'h78:8'h7B]}) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] nonterm();
    return $urandom & 32'hEFFF_FFFF;
  endfunction

  function automatic logic [31:0] termw();
    return ($urandom & 32'h0FFF_0FFF) | 32'h5000_5000;
  endfunction

  // Monitor: pick ready first, then record the beat the next edge will take.
  always @(negedge clk) begin
    if (!rst_n) begin
      pkt_ready = 1'b0;
      xfer_done = 1'b0;
    end else begin
      pkt_ready = rdy_en && ($urandom % 4 != 0);
      xfer_done = done_en && xfer_active && ($urandom % 3 == 0);
      if (pkt_valid && pkt_ready) begin
        rx_words++;
        if (exp_w.size() == 0) check(1'b0, "R10 unexpected packet word", {31'd0, pkt_last, pkt_data}, 64'd0);
        else begin
          logic [31:0] ew; logic el; string et;
          ew = exp_w.pop_front(); el = exp_l.pop_front(); et = exp_t.pop_front();
          check(pkt_data == ew && pkt_last == el, et, {31'd0, pkt_last, pkt_data}, {31'd0, el, ew});
        end
      end
      if (xfer_start) begin
        if (exp_x.size() == 0) check(1'b0, "R5 unexpected transfer", {31'd0, xfer_read, xfer_pos}, 64'd0);
        else begin
          logic [64:0] ex;
          ex = exp_x.pop_front();
          check({xfer_read, xfer_pos, xfer_size} == ex, "R5 transfer fields",
                {xfer_pos, xfer_size}, ex[63:0]);
          check(xfer_read == ex[64], "R5 transfer direction", {63'd0, xfer_read}, {63'd0, ex[64]});
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  task automatic push_word(input logic [31:0] w);
    bit ok;
    in_valid = 1'b1; in_data = w;
    forever begin
      ok = in_ready;
      @(negedge clk);
      if (ok) break;
    end
    in_valid = 1'b0;
  endtask

  task automatic send_pkt(input logic [31:0] pw [16], input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_w.push_back(pw[i]); exp_l.push_back(i == n - 1); exp_t.push_back(tag);
    end
    for (int i = 0; i < n; i++) push_word(pw[i]);
  endtask

  task automatic gen_fixed(input logic [7:0] op);
    logic [31:0] pw [16];
    int n;
    n = bench_extra(op) + 1;
    pw[0] = {op, 24'($urandom)};
    for (int i = 1; i < 16; i++) pw[i] = $urandom;
    send_pkt(pw, n, "R1 fixed-length packet");
  endtask

  // t = terminator index; 12 means none (R4 forced close).
  task automatic gen_flat(input int t);
    logic [31:0] pw [16];
    int n;
    n = (t <= 11) ? t + 1 : 12;
    pw[0] = {8'h48 | 8'($urandom % 8), 24'($urandom)};
    for (int i = 1; i < 16; i++)
      pw[i] = (i == t) ? termw() : ((i < 3 && $urandom % 2 == 0) ? termw() : nonterm());
    send_pkt(pw, n, (t <= 11) ? "R2 flat polyline" : "R4 flat polyline cap");
  endtask

  task automatic gen_shaded(input int t);
    logic [31:0] pw [16];
    int n;
    n = (t <= 10) ? t + 1 : 12;
    pw[0] = {8'h58 | 8'($urandom % 8), 24'($urandom)};
    for (int i = 1; i < 16; i++)
      pw[i] = (i == t) ? termw() : (((i % 2 == 1) || i < 4) && $urandom % 2 == 0) ? termw() : nonterm();
    send_pkt(pw, n, (t <= 10) ? "R3 shaded polyline" : "R4 shaded polyline cap");
  endtask

  task automatic gen_xfer(input logic [7:0] op);
    logic [31:0] p, s;
    p = $urandom; s = $urandom;
    exp_x.push_back({op[7:5] == 3'b110, p, s});
    push_word({op, 24'($urandom)});
    push_word(p);
    push_word(s);
  endtask

  task automatic gen_env();
    logic [2:0] i;
    logic [31:0] w;
    i = 3'($urandom % 8);
    w = {5'b11100, i, 24'($urandom)};
    sh_m[i] = w;
    push_word(w);
  endtask

  task automatic drain();
    while (exp_w.size() != 0 || exp_x.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  task automatic check_shadow(input string tag);
    for (int i = 0; i < 8; i++) begin
      shd_sel = 3'(i);
      #1;
      check(shd_data == sh_m[i], tag, {32'd0, shd_data}, {32'd0, sh_m[i]});
    end
    check(status_word == {sh_m[6][1:0], sh_m[1][10:0]}, "R9 status mirror",
          {51'd0, status_word}, {51'd0, sh_m[6][1:0], sh_m[1][10:0]});
  endtask

  initial begin
    logic [7:0] op;
    int w0;
    void'($urandom(32'd2024));
    for (int i = 0; i < 8; i++) sh_m[i] = (32'hE0 + 32'(i)) << 24;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 reset state
    check(!pkt_valid && !xfer_active && in_ready, "R8 idle outputs after reset",
          {61'd0, pkt_valid, xfer_active, in_ready}, 64'd1);
    check(status_word == 13'd0, "R8 status after reset", {51'd0, status_word}, 64'd0);
    check_shadow("R8 shadow reset value");

    // R1 directed lengths
    gen_fixed(8'h02); gen_fixed(8'h20); gen_fixed(8'h3C);
    gen_fixed(8'h80); gen_fixed(8'h00); gen_fixed(8'hE8);
    // R2 R3 R4 directed polylines
    gen_flat(3); gen_flat(11); gen_flat(12);
    gen_shaded(4); gen_shaded(10); gen_shaded(12);
    // R5 directed transfers
    gen_xfer(8'hA0); gen_xfer(8'hC0); gen_xfer(8'hBF); gen_xfer(8'hDF);
    drain();

    // Random mix
    for (int k = 0; k < 250; k++) begin
      case ($urandom % 6)
        0: begin
          do op = 8'($urandom);
          while (op inside {[8'h48:8'h4F], [8'h58:8'h5F], [8'hA0:8'hE7]});
          gen_fixed(op);
        end
        1: gen_flat(3 + int'($urandom % 10));
        2: gen_shaded(4 + 2 * int'($urandom % 5));
        3: gen_xfer(8'hA0 + 8'($urandom % 64));
        default: gen_env();
      endcase
    end
    drain();
    check_shadow("R7 shadow capture");

    // R10 partial packet held, completed later
    begin
      logic [31:0] pw [16];
      pw[0] = {8'h2C, 24'h123456};
      for (int i = 1; i < 16; i++) pw[i] = $urandom;
      for (int i = 0; i < 9; i++) begin
        exp_w.push_back(pw[i]); exp_l.push_back(i == 8); exp_t.push_back("R10 resumed packet");
      end
      for (int i = 0; i < 5; i++) push_word(pw[i]);
      repeat (12) @(negedge clk);
      check(!pkt_valid && rx_words >= 0, "R10 partial packet not emitted", {63'd0, pkt_valid}, 64'd0);
      for (int i = 5; i < 9; i++) push_word(pw[i]);
      drain();
    end

    // R12 FIFO fills behind a blocked packet
    rdy_en = 1'b0;
    gen_fixed(8'h3C);
    repeat (20) @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      exp_w.push_back({8'h00, 24'(i)}); exp_l.push_back(1'b1); exp_t.push_back("R12 queued word");
      push_word({8'h00, 24'(i)});
    end
    check(!in_ready, "R12 in_ready low when full", {63'd0, in_ready}, 64'd0);
    check(pkt_valid, "R10 packet held while ready low", {63'd0, pkt_valid}, 64'd1);
    rdy_en = 1'b1;
    drain();

    // R6 stall during transfer, then R11 flush
    done_en = 1'b0;
    gen_xfer(8'hC4);
    push_word(32'h0000_0077);
    while (!xfer_active) @(negedge clk);
    w0 = rx_words;
    repeat (20) @(negedge clk);
    check(rx_words == w0 && !pkt_valid && xfer_active, "R6 no consumption during transfer",
          {32'(rx_words), 31'd0, pkt_valid}, {32'(w0), 32'd0});
    cmd_reset = 1'b1;
    @(negedge clk);
    cmd_reset = 1'b0;
    check(!xfer_active, "R11 transfer ended by cmd_reset", {63'd0, xfer_active}, 64'd0);
    done_en = 1'b1;
    gen_fixed(8'h20);
    drain();

    // R11 partial packet discarded, shadow kept
    push_word({8'h3C, 24'h0});
    push_word(32'h1); push_word(32'h2); push_word(32'h3);
    repeat (10) @(negedge clk);
    cmd_reset = 1'b1;
    @(negedge clk);
    cmd_reset = 1'b0;
    gen_fixed(8'h00);
    gen_fixed(8'h02);
    drain();
    check_shadow("R11 shadow kept across cmd_reset");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule